// File: doc/BRIEF.md
# Pin Event Interrupt Controller

This block watches a bank of input pins and turns their activity into interrupt events for two processors. Each pin has four event types. Two are level events, for pin low and pin high. Two are edge events, for a falling and a rising transition.

The two level events follow the synchronised pin directly and are never stored. The two edge events are sticky: once set, an edge bit stays set until software clears it by writing a 1 to that bit. All event state is grouped into 32-bit words. Each word holds eight pins with four bits per pin. Writes to the block address one of these words through a small write port.

Each processor has its own enable vector. The block drives a masked status vector for each processor and a single summary interrupt line for each. A third enable vector chooses which events raise a wake request while the system is dormant. The pins are asynchronous, so they pass through a two-flop synchroniser first. An edge is found by comparing the synchronised value with its value one cycle earlier.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After reset, all enable vectors and all edge bits are zero, and both interrupt lines and the wake output are low.
- R2: For each pin, event bit 0 is 1 while the synchronised pin is low and bit 1 is 1 while it is high. A change on the pin reaches these bits two clock edges later. The bits are not latched: they drop as soon as the pin leaves that level.
- R3: For each pin, event bit 2 is set by a high-to-low transition of the synchronised pin and bit 3 by a low-to-high transition. An edge bit is set on the clock edge that follows the cycle in which the new synchronised level first appears. Edge bits stay set until they are cleared.
- R4: A write with selector 0 clears every edge bit of the addressed word whose data bit is 1. Data bits that are 0 leave their edge bits unchanged. Data bits that land on level bits (bits 0 and 1 of each nibble) have no effect.
- R5: If an edge is detected in the same cycle as a clear of that same edge bit, the bit stays set.
- R6: Pin p owns bits 4*(p mod 8) to 4*(p mod 8)+3 of word p/8, and bit 4p of each flat output vector. A write changes only the pins of the word given by the word index. Bits that land on pin positions at or above the pin count are ignored.
- R7: A write with selector 1 loads processor 0's enable vector for the addressed word, and selector 2 loads processor 1's enable vector. Each processor's masked status is the raw event vector ANDed with its own enable vector. The two processors are independent of each other.
- R8: Each processor's interrupt line is high exactly when any bit of that processor's masked status is set.
- R9: A write with selector 3 loads the wake enable vector. The wake output is high exactly when any raw event bit is set whose wake enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Asynchronous pin levels |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 clear edges, 1 processor 0 enable, 2 processor 1 enable, 3 wake enable |
| wr_word_i | input | IW | Index of the word being written |
| wr_data_i | input | 32 | Write data, four bits per pin |
| raw_o | output | 4*NPINS | Raw event bits, nibble p for pin p |
| cpu0_stat_o | output | 4*NPINS | Processor 0 masked status |
| cpu1_stat_o | output | 4*NPINS | Processor 1 masked status |
| irq_o | output | 2 | Summary interrupt line for each processor |
| wake_o | output | 1 | Dormant wake request |

## Verification
The pins are driven with four kinds of pattern. A walking one separates the pins from each other and shows whether each nibble sits at its correct position. A whole-bank toggle produces simultaneous rising and falling edges. An alternating mask gives neighbouring pins opposite levels. A long pseudo-random sequence shows whether edges are lost or invented across many cycles.

Clear writes are applied in three ways. Some set only level bits, which shows that they are ignored. Some cover partial words, which shows that the selection is per bit. One is timed to land in the same cycle as a new edge on that bit, which exercises the case where setting must win.

The enable vectors are chosen to differ between the two processors and the wake path, so that each masked view is checked against its own enable vector.

// File: rtl/gpio_event_ctrl.sv
module gpio_event_ctrl #(
  parameter int NPINS = 30
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPINS-1:0]              pin_i,
  input  logic                          wr_en_i,
  input  logic [1:0]                    wr_sel_i,
  input  logic [((NPINS+7)/8 > 1 ? $clog2((NPINS+7)/8) : 1)-1:0] wr_word_i,
  input  logic [31:0]                   wr_data_i,
  output logic [4*NPINS-1:0]            raw_o,
  output logic [4*NPINS-1:0]            cpu0_stat_o,
  output logic [4*NPINS-1:0]            cpu1_stat_o,
  output logic [1:0]                    irq_o,
  output logic                          wake_o
);
  localparam int NWORDS = (NPINS + 7) / 8;
  localparam int IW     = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int FW     = 4 * NPINS;

  logic [NPINS-1:0] meta_q, sync_q, prev_q, fall_q, rise_q;
  logic [FW-1:0]    en0_q, en1_q, enw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int W = p / 8;
    localparam int B = 4 * (p % 8);
    logic hit;
    assign hit = wr_en_i && (wr_word_i == IW'(W));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fall_q[p]        <= 1'b0;
        rise_q[p]        <= 1'b0;
        en0_q[4*p +: 4]  <= '0;
        en1_q[4*p +: 4]  <= '0;
        enw_q[4*p +: 4]  <= '0;
      end else begin
        fall_q[p] <= (prev_q[p] & ~sync_q[p]) |
                     (fall_q[p] & ~(hit && wr_sel_i == 2'd0 && wr_data_i[B+2]));
        rise_q[p] <= (~prev_q[p] & sync_q[p]) |
                     (rise_q[p] & ~(hit && wr_sel_i == 2'd0 && wr_data_i[B+3]));
        if (hit && wr_sel_i == 2'd1) en0_q[4*p +: 4] <= wr_data_i[B +: 4];
        if (hit && wr_sel_i == 2'd2) en1_q[4*p +: 4] <= wr_data_i[B +: 4];
        if (hit && wr_sel_i == 2'd3) enw_q[4*p +: 4] <= wr_data_i[B +: 4];
      end
    end

    assign raw_o[4*p +: 4] = {rise_q[p], fall_q[p], sync_q[p], ~sync_q[p]};
  end

  assign cpu0_stat_o = raw_o & en0_q;
  assign cpu1_stat_o = raw_o & en1_q;
  assign irq_o       = {|cpu1_stat_o, |cpu0_stat_o};
  assign wake_o      = |(raw_o & enw_q);
endmodule

// File: rtl/gpio_event_ctrl_chk.sv
module gpio_event_ctrl_chk #(
  parameter int NPINS = 30
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en_i,
  input logic [1:0]           wr_sel_i,
  input logic [4*NPINS-1:0]   raw_o,
  input logic [4*NPINS-1:0]   cpu0_stat_o,
  input logic [4*NPINS-1:0]   cpu1_stat_o,
  input logic [1:0]           irq_o,
  input logic                 wake_o
);
  localparam logic [4*NPINS-1:0] EMASK = {NPINS{4'b1100}};

  assert_edge_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && wr_sel_i == 2'd0) |=>
      ((raw_o & $past(raw_o) & EMASK) == ($past(raw_o) & EMASK)));

  assert_cpu0_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu0_stat_o & ~raw_o) == '0);

  assert_cpu1_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu1_stat_o & ~raw_o) == '0);

  assert_irq0_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[0]) |-> (cpu0_stat_o != '0));

  assert_irq1_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o[1]) |-> (cpu1_stat_o != '0));

  assert_wake_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (raw_o != '0));
endmodule

bind gpio_event_ctrl gpio_event_ctrl_chk #(.NPINS(NPINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .raw_o(raw_o), .cpu0_stat_o(cpu0_stat_o), .cpu1_stat_o(cpu1_stat_o),
  .irq_o(irq_o), .wake_o(wake_o));

// File: tb/gpio_event_ctrl_tb.sv
module gpio_event_ctrl_tb_top;
  localparam int N  = 30;
  localparam int FW = 4 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_i = '0;
  logic          wr_en_i = 1'b0;
  logic [1:0]    wr_sel_i = '0;
  logic [1:0]    wr_word_i = '0;
  logic [31:0]   wr_data_i = '0;
  logic [FW-1:0] raw_o, cpu0_stat_o, cpu1_stat_o;
  logic [1:0]    irq_o;
  logic          wake_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_event_ctrl #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_word_i(wr_word_i), .wr_data_i(wr_data_i),
    .raw_o(raw_o), .cpu0_stat_o(cpu0_stat_o), .cpu1_stat_o(cpu1_stat_o),
    .irq_o(irq_o), .wake_o(wake_o));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit m_s1[N], m_s2[N], m_pv[N], m_fall[N], m_rise[N];
  logic [FW-1:0] m_en0, m_en1, m_enw;
  logic [FW-1:0] e_raw, e_lvl, e_edg;
  localparam logic [FW-1:0] LMASK = {N{4'b0011}};
  localparam logic [FW-1:0] EMASK = {N{4'b1100}};

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        m_s1[p] = 0; m_s2[p] = 0; m_pv[p] = 0; m_fall[p] = 0; m_rise[p] = 0;
      end
      m_en0 = '0; m_en1 = '0; m_enw = '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        int b;
        bit hit;
        b = 4 * (p % 8);
        hit = wr_en_i && (int'(wr_word_i) == p / 8);
        m_fall[p] = (m_pv[p] && !m_s2[p]) || (m_fall[p] && !(hit && wr_sel_i == 0 && wr_data_i[b+2]));
        m_rise[p] = (!m_pv[p] && m_s2[p]) || (m_rise[p] && !(hit && wr_sel_i == 0 && wr_data_i[b+3]));
        for (int e = 0; e < 4; e++) begin
          if (hit && wr_sel_i == 1) m_en0[4*p+e] = wr_data_i[b+e];
          if (hit && wr_sel_i == 2) m_en1[4*p+e] = wr_data_i[b+e];
          if (hit && wr_sel_i == 3) m_enw[4*p+e] = wr_data_i[b+e];
        end
        m_pv[p] = m_s2[p]; m_s2[p] = m_s1[p]; m_s1[p] = pin_i[p];
      end
    end
    #2;
    for (int p = 0; p < N; p++)
      e_raw[4*p +: 4] = {m_rise[p], m_fall[p], m_s2[p], !m_s2[p]};
    if (rst_n && !done) begin
      chk((raw_o & LMASK) == (e_raw & LMASK), "R2 level bits", raw_o & LMASK, e_raw & LMASK);
      chk((raw_o & EMASK) == (e_raw & EMASK), "R3/R4 edge bits", raw_o & EMASK, e_raw & EMASK);
      chk(cpu0_stat_o == (e_raw & m_en0), "R7 cpu0 status", cpu0_stat_o, e_raw & m_en0);
      chk(cpu1_stat_o == (e_raw & m_en1), "R7 cpu1 status", cpu1_stat_o, e_raw & m_en1);
      chk(irq_o == {|(e_raw & m_en1), |(e_raw & m_en0)}, "R8 irq lines", irq_o,
          {|(e_raw & m_en1), |(e_raw & m_en0)});
      chk(wake_o == |(e_raw & m_enw), "R9 wake", wake_o, |(e_raw & m_enw));
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] word, input logic [31:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_word_i = word; wr_data_i = data;
    cyc();
    wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    cyc(3);
    rst_n = 1'b1;
    cyc();
    chk(irq_o == 2'b00 && wake_o == 1'b0, "R1 reset outputs", {irq_o, wake_o}, 0);
    chk((raw_o & EMASK) == '0, "R1 reset edges", raw_o & EMASK, 0);

    wr(2'd1, 2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 2'd1, 32'h0000_0F00);
    wr(2'd2, 2'd1, 32'h8888_8888);
    wr(2'd2, 2'd2, 32'h0000_0002);
    wr(2'd3, 2'd3, 32'h4444_4444);

    // R6 walking one
    for (int p = 0; p < N; p++) begin
      pin_i = N'(1) << p;
      cyc(3);
      chk(raw_o[4*p +: 4] == 4'b1010, "R6 walking nibble", raw_o[4*p +: 4], 4'b1010);
    end
    pin_i = '0;
    cyc(3);

    // R2 level not latched
    chk(raw_o[1:0] == 2'b01, "R2 level low after fall", raw_o[1:0], 2'b01);

    // R4 level-bit-only clear has no effect, partial clears
    wr(2'd0, 2'd0, 32'h3333_3333);
    chk(raw_o[3:2] == 2'b11, "R4 level write ignored", raw_o[3:2], 2'b11);
    wr(2'd0, 2'd0, 32'h0000_0008);
    chk(raw_o[3:2] == 2'b01, "R4 partial clear", raw_o[3:2], 2'b01);
    for (int w = 0; w < 4; w++) wr(2'd0, 2'(w), 32'hFFFF_FFFF);
    chk((raw_o & EMASK) == '0, "R4 full clear", raw_o & EMASK, 0);

    // bank toggle and alternating
    pin_i = '1; cyc(4);
    pin_i = '0; cyc(4);
    pin_i = 30'h1555_5555; cyc(4);
    pin_i = 30'h2AAA_AAAA; cyc(4);
    for (int w = 0; w < 4; w++) wr(2'd0, 2'(w), 32'hFFFF_FFFF);
    cyc(2);

    // R5 coincident edge and clear on pin 9
    pin_i = '0; cyc(4);
    for (int w = 0; w < 4; w++) wr(2'd0, 2'(w), 32'hFFFF_FFFF);
    pin_i[9] = 1'b1;
    cyc(2);
    wr(2'd0, 2'd1, 32'h0000_0080);
    chk(raw_o[4*9+3] == 1'b1, "R5 edge beats clear", raw_o[4*9+3], 1'b1);

    // pseudo-random activity
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      pin_i = lfsr[N-1:0];
      if (i % 17 == 5) wr(2'd0, lfsr[3:2], lfsr ^ 32'h5A5A_5A5A);
      else if (i % 41 == 9) wr(2'd2, lfsr[5:4], lfsr);
      else cyc();
    end

    // R8 lines drop when enables are cleared
    for (int w = 0; w < 4; w++) begin
      wr(2'd1, 2'(w), 32'h0);
      wr(2'd2, 2'(w), 32'h0);
      wr(2'd3, 2'(w), 32'h0);
    end
    cyc();
    chk(irq_o == 2'b00 && wake_o == 1'b0, "R8 lines low with no enables", {irq_o, wake_o}, 0);
    cyc(2);
    finish_run();
  end
endmodule